// File: doc/BRIEF.md
# Ethernet Transmit Frame Word Packer

The packer takes one outgoing Ethernet frame as a stream of bytes and turns it into 32-bit words for a transmit FIFO. The frame starts at the destination address and carries no FCS. Word 0 of the output frame can only be built once the frame length is known. For this reason the block stores the whole frame internally, and it starts emitting words only after the byte marked last has been taken.

Word 0 has two parts. Its low half holds the payload length, which is the frame byte count minus the 14 header bytes. Its high half holds the first two frame bytes. Each word after that holds the next four bytes in little-endian lane order, and the unused lanes of the final word are filled with zeros.

After the final word has been handed over, the block raises a one-cycle transmit-start strobe. A frame that is too long or too short is dropped with an error pulse and produces no words. In either case a done pulse marks the end of the frame.

Top module: `eth_tx_word_packer`

## Requirements
- R1: Bits 15:0 of word 0 equal N-14, where N is the number of bytes in the frame.
- R2: Bits 23:16 of word 0 hold frame byte 0, and bits 31:24 hold frame byte 1.
- R3: Word k (k >= 1) holds frame bytes 4k-2 to 4k+1. The lowest-addressed byte is in bits 7:0 and the highest in bits 31:24.
- R4: When N-2 is not a multiple of 4, the last word carries the leftover 1 to 3 bytes in its low lanes and zeros in every higher lane.
- R5: A frame of N bytes produces exactly ceil((N+2)/4) output words, and output begins only after the last input byte.
- R6: A frame of more than 2046 bytes is rejected. The cycle after its last byte is taken, error and done are both high for one cycle, and no word is ever presented for that frame.
- R7: A frame of fewer than 14 bytes is rejected in the same way as R6.
- R8: The cycle after the final word is accepted, the transmit-start strobe is high for exactly one cycle, and done is high with it while error stays low.
- R9: For an accepted frame, input ready is low from the cycle after the last byte until the cycle after the start strobe. While output valid is high and output ready is low, the word holds steady.
- R10: After reset, input ready is high, and output valid, start, done and error are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid_i | input | 1 | Input byte is valid |
| byte_data_i | input | 8 | Frame byte |
| byte_last_i | input | 1 | Marks the final byte of the frame |
| byte_ready_o | output | 1 | Block can take a byte |
| word_valid_o | output | 1 | Output word is valid |
| word_data_o | output | 32 | Packed FIFO word |
| word_ready_i | input | 1 | Sink takes the word |
| tx_start_o | output | 1 | One-cycle transmit-start strobe |
| frame_err_o | output | 1 | Frame rejected for its size |
| frame_done_o | output | 1 | Frame finished, either sent or rejected |

## Verification
A wrong byte counter or a wrong store index shows up directly in the output words. The length field, a byte lane or the word count of the next sent frame is off, and the bench sees this within one frame. A wrong emitter index shows up as a missing word, an extra word or a missing start strobe, which the bench reports as soon as the done pulse of that frame arrives. A wrong size decision shows up in the first cycle after the last byte: error is raised where none is expected, or words appear where none should. Frames of 13, 14, 2046 and 2047 bytes fall on both sides of each size limit.

// File: rtl/eth_txp_pkg.sv
package eth_txp_pkg;

   localparam int unsigned LANE_W = 8;
   localparam int unsigned LANES  = 4;

   typedef enum logic [0:0] {
      COL_TAKE = 1'b0,
      COL_HOLD = 1'b1
   } col_state_e;

   typedef enum logic [0:0] {
      EMT_IDLE = 1'b0,
      EMT_SEND = 1'b1
   } emt_state_e;

   function automatic int unsigned words_for(input int unsigned nbytes);
      return (nbytes + 2 + LANES - 1) / LANES;
   endfunction

endpackage

// File: rtl/txp_byte_collector.sv
module txp_byte_collector
   import eth_txp_pkg::*;
#(
   parameter int unsigned MAX_BYTES = 2046,
   parameter int unsigned MIN_BYTES = 14,
   localparam int unsigned CNT_W    = $clog2(MAX_BYTES + 1),
   localparam int unsigned POS_W    = $clog2(MAX_BYTES + 3),
   localparam int unsigned DEPTH_W  = words_for(MAX_BYTES),
   localparam int unsigned WIDX_W   = $clog2(DEPTH_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   input  logic              in_last,
   output logic              in_ready,
   output logic              wr_en,
   output logic [WIDX_W-1:0] wr_word,
   output logic [1:0]        wr_lane,
   output logic [7:0]        wr_data,
   output logic              launch,
   output logic [CNT_W-1:0]  launch_bytes,
   output logic              reject,
   input  logic              emit_done
);

   localparam int unsigned TOT_W = CNT_W + 1;

   col_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              ovf_q;
   logic              rej_q;
   logic              accept;
   logic              at_cap;
   logic              too_long;
   logic              too_short;
   logic [POS_W-1:0]  pos;
   logic [TOT_W-1:0]  total;

   assign in_ready  = (state_q == COL_TAKE);
   assign accept    = in_valid & in_ready;
   assign at_cap    = (cnt_q == CNT_W'(MAX_BYTES));
   assign pos       = POS_W'(cnt_q) + POS_W'(2);
   assign total     = TOT_W'(cnt_q) + TOT_W'(1);
   assign too_long  = ovf_q | at_cap;
   assign too_short = (total < TOT_W'(MIN_BYTES));

   // byte k of the frame lives at packed position k+2
   assign wr_en   = accept & ~too_long;
   assign wr_word = WIDX_W'(pos >> 2);
   assign wr_lane = pos[1:0];
   assign wr_data = in_data;

   assign launch       = accept & in_last & ~too_long & ~too_short;
   assign launch_bytes = CNT_W'(total);
   assign reject       = rej_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= COL_TAKE;
         cnt_q   <= '0;
         ovf_q   <= 1'b0;
         rej_q   <= 1'b0;
      end else begin
         rej_q <= 1'b0;
         unique case (state_q)
            COL_TAKE: begin
               if (accept) begin
                  if (in_last) begin
                     cnt_q <= '0;
                     ovf_q <= 1'b0;
                     if (too_long || too_short) begin
                        rej_q <= 1'b1;
                     end else begin
                        state_q <= COL_HOLD;
                     end
                  end else if (at_cap) begin
                     ovf_q <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
            end
            COL_HOLD: begin
               if (emit_done) begin
                  state_q <= COL_TAKE;
               end
            end
            default: state_q <= COL_TAKE;
         endcase
      end
   end

endmodule

// File: rtl/txp_lane_store.sv
module txp_lane_store
   import eth_txp_pkg::*;
#(
   parameter int unsigned DEPTH_W = 512,
   localparam int unsigned WIDX_W = $clog2(DEPTH_W)
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [WIDX_W-1:0]        wr_word,
   input  logic [1:0]               wr_lane,
   input  logic [7:0]               wr_data,
   input  logic [WIDX_W-1:0]        rd_word,
   output logic [LANES*LANE_W-1:0]  rd_data
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH_W];

      always_ff @(posedge clk) begin
         if (wr_en && (wr_lane == 2'(g))) begin
            mem[wr_word] <= wr_data;
         end
      end

      assign rd_data[g*LANE_W +: LANE_W] = mem[rd_word];
   end

endmodule

// File: rtl/txp_word_emitter.sv
module txp_word_emitter
   import eth_txp_pkg::*;
#(
   parameter int unsigned MAX_BYTES = 2046,
   parameter int unsigned HDR_BYTES = 14,
   parameter int unsigned LEN_W     = 16,
   localparam int unsigned CNT_W    = $clog2(MAX_BYTES + 1),
   localparam int unsigned POS_W    = $clog2(MAX_BYTES + 3),
   localparam int unsigned DEPTH_W  = words_for(MAX_BYTES),
   localparam int unsigned WIDX_W   = $clog2(DEPTH_W),
   localparam int unsigned WORD_W   = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [CNT_W-1:0]  launch_bytes,
   output logic [WIDX_W-1:0] rd_word,
   input  logic [WORD_W-1:0] rd_data,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data,
   input  logic              out_ready,
   output logic              tx_start
);

   emt_state_e        state_q;
   logic [WIDX_W-1:0] widx_q;
   logic [WIDX_W-1:0] last_idx_q;
   logic [1:0]        last_lane_q;
   logic [LEN_W-1:0]  len_q;
   logic              start_q;
   logic [POS_W-1:0]  last_pos;
   logic              is_first;
   logic              is_final;
   logic [WORD_W-1:0] len_word;

   assign last_pos  = POS_W'(launch_bytes) + POS_W'(1);
   assign is_first  = (widx_q == '0);
   assign is_final  = (widx_q == last_idx_q);
   assign len_word  = WORD_W'(len_q);
   assign rd_word   = widx_q;
   assign out_valid = (state_q == EMT_SEND);
   assign tx_start  = start_q;

   // lanes 0..1 of word 0 carry the length; lanes past the tail are padded
   for (genvar g = 0; g < LANES; g++) begin : g_out
      if (g < 2) begin : g_hdr
         assign out_data[g*LANE_W +: LANE_W] =
            is_first ? len_word[g*LANE_W +: LANE_W]
                     : ((is_final && (2'(g) > last_lane_q)) ? '0
                        : rd_data[g*LANE_W +: LANE_W]);
      end else begin : g_body
         assign out_data[g*LANE_W +: LANE_W] =
            (is_final && (2'(g) > last_lane_q)) ? '0
                                                : rd_data[g*LANE_W +: LANE_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= EMT_IDLE;
         widx_q      <= '0;
         last_idx_q  <= '0;
         last_lane_q <= '0;
         len_q       <= '0;
         start_q     <= 1'b0;
      end else begin
         start_q <= 1'b0;
         unique case (state_q)
            EMT_IDLE: begin
               if (launch) begin
                  state_q     <= EMT_SEND;
                  widx_q      <= '0;
                  last_idx_q  <= WIDX_W'(last_pos >> 2);
                  last_lane_q <= last_pos[1:0];
                  len_q       <= LEN_W'(launch_bytes - CNT_W'(HDR_BYTES));
               end
            end
            EMT_SEND: begin
               if (out_ready) begin
                  if (is_final) begin
                     state_q <= EMT_IDLE;
                     start_q <= 1'b1;
                  end else begin
                     widx_q <= widx_q + WIDX_W'(1);
                  end
               end
            end
            default: state_q <= EMT_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/eth_tx_word_packer.sv
module eth_tx_word_packer
   import eth_txp_pkg::*;
#(
   parameter int unsigned MAX_BYTES = 2046,
   parameter int unsigned MIN_BYTES = 14,
   parameter int unsigned HDR_BYTES = 14,
   parameter int unsigned LEN_W     = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        byte_valid_i,
   input  logic [7:0]  byte_data_i,
   input  logic        byte_last_i,
   output logic        byte_ready_o,
   output logic        word_valid_o,
   output logic [31:0] word_data_o,
   input  logic        word_ready_i,
   output logic        tx_start_o,
   output logic        frame_err_o,
   output logic        frame_done_o
);

   localparam int unsigned CNT_W   = $clog2(MAX_BYTES + 1);
   localparam int unsigned DEPTH_W = words_for(MAX_BYTES);
   localparam int unsigned WIDX_W  = $clog2(DEPTH_W);

   if (MIN_BYTES < HDR_BYTES) begin : g_bad_min
      $error("MIN_BYTES must cover the header so the length field stays non-negative");
   end
   if (MAX_BYTES < MIN_BYTES) begin : g_bad_max
      $error("MAX_BYTES must not be below MIN_BYTES");
   end
   if ((MAX_BYTES - HDR_BYTES) >= (1 << LEN_W) || LEN_W > 16) begin : g_bad_len
      $error("length field cannot hold the largest payload");
   end

   logic              wr_en;
   logic [WIDX_W-1:0] wr_word;
   logic [1:0]        wr_lane;
   logic [7:0]        wr_data;
   logic              launch;
   logic [CNT_W-1:0]  launch_bytes;
   logic              reject;
   logic [WIDX_W-1:0] rd_word;
   logic [31:0]       rd_data;
   logic              start;

   txp_byte_collector #(
      .MAX_BYTES (MAX_BYTES),
      .MIN_BYTES (MIN_BYTES)
   ) u_col (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (byte_valid_i),
      .in_data      (byte_data_i),
      .in_last      (byte_last_i),
      .in_ready     (byte_ready_o),
      .wr_en        (wr_en),
      .wr_word      (wr_word),
      .wr_lane      (wr_lane),
      .wr_data      (wr_data),
      .launch       (launch),
      .launch_bytes (launch_bytes),
      .reject       (reject),
      .emit_done    (start)
   );

   txp_lane_store #(
      .DEPTH_W (DEPTH_W)
   ) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_word (wr_word),
      .wr_lane (wr_lane),
      .wr_data (wr_data),
      .rd_word (rd_word),
      .rd_data (rd_data)
   );

   txp_word_emitter #(
      .MAX_BYTES (MAX_BYTES),
      .HDR_BYTES (HDR_BYTES),
      .LEN_W     (LEN_W)
   ) u_emt (
      .clk          (clk),
      .rst_n        (rst_n),
      .launch       (launch),
      .launch_bytes (launch_bytes),
      .rd_word      (rd_word),
      .rd_data      (rd_data),
      .out_valid    (word_valid_o),
      .out_data     (word_data_o),
      .out_ready    (word_ready_i),
      .tx_start     (start)
   );

   assign tx_start_o   = start;
   assign frame_err_o  = reject;
   assign frame_done_o = start | reject;

endmodule

// File: rtl/eth_txp_checker.sv
module eth_txp_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        byte_ready_o,
   input logic        word_valid_o,
   input logic [31:0] word_data_o,
   input logic        word_ready_i,
   input logic        tx_start_o,
   input logic        frame_err_o,
   input logic        frame_done_o
);

   p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start_o |=> !tx_start_o);

   p_done_with_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start_o |-> (frame_done_o && !frame_err_o));

   p_start_after_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start_o |-> $past(word_valid_o && word_ready_i));

   p_err_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |-> frame_done_o);

   p_no_words_on_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |-> !word_valid_o);

   p_input_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |-> !byte_ready_o);

   p_hold_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_o && !word_ready_i) |=> (word_valid_o && $stable(word_data_o)));

endmodule

bind eth_tx_word_packer eth_txp_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .byte_ready_o (byte_ready_o),
   .word_valid_o (word_valid_o),
   .word_data_o  (word_data_o),
   .word_ready_i (word_ready_i),
   .tx_start_o   (tx_start_o),
   .frame_err_o  (frame_err_o),
   .frame_done_o (frame_done_o)
);

// File: tb/eth_tx_word_packer_tb_top.sv
`timescale 1ns/1ps
module eth_tx_word_packer_tb_top;

   localparam int MAXB = 2046;
   localparam int MINB = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_valid_i = 1'b0;
   logic [7:0]  byte_data_i = '0;
   logic        byte_last_i = 1'b0;
   logic        byte_ready_o;
   logic        word_valid_o;
   logic [31:0] word_data_o;
   logic        word_ready_i = 1'b0;
   logic        tx_start_o;
   logic        frame_err_o;
   logic        frame_done_o;

   always #2.5 clk = ~clk;

   eth_tx_word_packer dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .byte_valid_i (byte_valid_i),
      .byte_data_i  (byte_data_i),
      .byte_last_i  (byte_last_i),
      .byte_ready_o (byte_ready_o),
      .word_valid_o (word_valid_o),
      .word_data_o  (word_data_o),
      .word_ready_i (word_ready_i),
      .tx_start_o   (tx_start_o),
      .frame_err_o  (frame_err_o),
      .frame_done_o (frame_done_o)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int rdy_pct = 70;
   int in_pct = 75;

   logic [7:0]  frame_b [$];
   logic [31:0] got_w [$];
   int hs_cyc = -1;
   int start_cyc = -1;
   int start_cnt = 0;
   int err_cnt = 0;
   int done_cnt = 0;
   bit start_no_done = 0;
   bit word_early = 0;
   bit byte_phase = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      #1;
      word_ready_i = (($urandom % 100) < rdy_pct);
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (word_valid_o && byte_phase) word_early = 1;
         if (word_valid_o && word_ready_i) begin
            got_w.push_back(word_data_o);
            hs_cyc = cyc;
         end
         if (tx_start_o) begin
            start_cnt++;
            start_cyc = cyc;
            if (!frame_done_o) start_no_done = 1;
         end
         if (frame_err_o) err_cnt++;
         if (frame_done_o) done_cnt++;
      end
   end

   function automatic logic [31:0] exp_word(input int w, input int n);
      logic [31:0] v = '0;
      logic [15:0] len = 16'(n - 14);
      for (int l = 0; l < 4; l++) begin
         int p = w * 4 + l;
         if (p < 2) v[l*8 +: 8] = len[l*8 +: 8];
         else if (p - 2 < n) v[l*8 +: 8] = frame_b[p - 2];
      end
      return v;
   endfunction

   task automatic run_frame(input int n, input int mode);
      bit bad = (n > MAXB) || (n < MINB);
      int nw = (n + 2 + 3) / 4;
      int t;
      frame_b.delete();
      for (int k = 0; k < n; k++)
         frame_b.push_back(mode == 1 ? 8'(k) : 8'($urandom));
      got_w.delete();
      start_cnt = 0; err_cnt = 0; done_cnt = 0; start_no_done = 0;
      word_early = 0; byte_phase = 1;
      for (int k = 0; k < n; k++) begin
         forever begin
            @(posedge clk); #1;
            byte_valid_i = (($urandom % 100) < in_pct) || (k == n - 1);
            byte_data_i  = frame_b[k];
            byte_last_i  = (k == n - 1);
            @(negedge clk);
            if (byte_valid_i && byte_ready_o) break;
         end
      end
      @(posedge clk); #1;
      byte_valid_i = 0; byte_last_i = 0;
      byte_phase = 0;
      @(negedge clk);
      check(!word_early, "R5", "word shown before last byte", word_early, 0);
      if (bad) begin
         check(frame_err_o && frame_done_o, bad && n < MINB ? "R7" : "R6",
               "err/done after last byte", {frame_err_o, frame_done_o}, 2'b11);
         check(byte_ready_o, bad && n < MINB ? "R7" : "R6", "ready stays open",
               byte_ready_o, 1);
         repeat (20) @(negedge clk);
         check(got_w.size() == 0 && start_cnt == 0, n < MINB ? "R7" : "R6",
               "words after reject", got_w.size(), 0);
         check(err_cnt == 1, n < MINB ? "R7" : "R6", "error pulse count", err_cnt, 1);
      end else begin
         check(!byte_ready_o, "R9", "ready low after last byte", byte_ready_o, 0);
         check(!frame_err_o, "R6", "no error on legal frame", frame_err_o, 0);
         t = 0;
         while (start_cnt == 0 && t < 8000) begin @(negedge clk); t++; end
         check(byte_ready_o, "R9", "ready back after start", byte_ready_o, 1);
         repeat (3) @(negedge clk);
         check(start_cnt == 1 && !start_no_done && done_cnt == 1 && err_cnt == 0,
               "R8", "single start with done", start_cnt, 1);
         check(start_cyc == hs_cyc + 1, "R8", "start timing", start_cyc, hs_cyc + 1);
         check(got_w.size() == nw, "R5", "word count", got_w.size(), nw);
         if (got_w.size() == nw) begin
            bit ok3 = 1;
            logic [31:0] bw = 0, be = 0;
            check(got_w[0][15:0] == exp_word(0, n)[15:0], "R1", "length field",
                  got_w[0][15:0], exp_word(0, n)[15:0]);
            check(got_w[0][31:16] == exp_word(0, n)[31:16], "R2", "first two bytes",
                  got_w[0][31:16], exp_word(0, n)[31:16]);
            for (int w = 1; w < nw - 1; w++)
               if (ok3 && got_w[w] != exp_word(w, n)) begin
                  ok3 = 0; bw = got_w[w]; be = exp_word(w, n);
               end
            check(ok3, "R3", "body word lanes", bw, be);
            check(got_w[nw-1] == exp_word(nw - 1, n), "R4", "tail word padding",
                  got_w[nw-1], exp_word(nw - 1, n));
         end
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'h1A2B3C4D));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(byte_ready_o && !word_valid_o && !tx_start_o && !frame_done_o && !frame_err_o,
            "R10", "reset state",
            {byte_ready_o, word_valid_o, tx_start_o, frame_done_o, frame_err_o}, 5'b10000);
      run_frame(14, 1);
      run_frame(13, 1);
      run_frame(1, 0);
      run_frame(60, 1);
      run_frame(61, 0);
      run_frame(62, 0);
      run_frame(63, 0);
      rdy_pct = 20;
      run_frame(64, 0);
      rdy_pct = 100; in_pct = 100;
      run_frame(MAXB, 0);
      run_frame(MAXB + 1, 0);
      run_frame(MAXB + 3, 0);
      in_pct = 75;
      for (int r = 0; r < 20; r++) begin
         rdy_pct = 30 + ($urandom % 71);
         run_frame(MINB + ($urandom % 300), 0);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule